// File: doc/BRIEF.md
# Tagged Associative Lookup Array

A small content-addressable store. Each entry holds a data word and a two-bit state tag that marks the entry as valid, empty or skipped. The block takes a search key and an optional bit mask. It compares them in parallel against the searchable field of every entry. It returns three results: a hit flag, a flag for more than one hit, and the index of the lowest-numbered hit. A combinational output always gives the lowest-numbered empty entry.

Each entry word is cut into fixed segments. A run-time setting gives some of those segments to associated data. The associated data is stored and read with the entry but does not take part in searches. Entries are written and read through one command port. The target index can come from the command itself, from a held index register, from the first empty entry, or from the last search result. Writes can be masked so that chosen bits keep their old contents.

Top module: `cam_tag_array`

## Requirements
- R1: After reset every entry is tagged empty (tag 2'b01) and holds zero data. `next_free` is 0, `free_valid` is 1, and `match_flag`, `multi_flag`, `match_addr` and `rd_valid` are 0.
- R2: A write (`cmd_op` 3'd2) stores `wr_data` and `wr_tag` at the index named by `addr_src`: 0 selects `bus_addr`, 1 the index register, 2 `next_free`, 3 the registered `match_addr`. The index register is loaded from `bus_addr` by `cmd_op` 3'd1. A write is dropped when source 2 has no empty entry or source 3 has no hit.
- R3: During a write, a data bit whose active-mask bit is 1 keeps its old value, and a bit whose mask bit is 0 takes `wr_data`. The active mask depends on `mask_sel`: 0 none, 1 `mask_a`, 2 `mask_b`, 3 the OR of both.
- R4: In a search (`cmd_op` 3'd4), a key bit whose active-mask bit is 1 is ignored, and a key bit whose mask bit is 0 must equal the stored bit.
- R5: The word is split into 16-bit segments. With the default layout, the `ram_segs` lowest segments are associated data and are never compared.
- R6: An automatic search (`cmp_forced` 0) can hit only entries tagged valid (2'b00).
- R7: A forced search (`cmp_forced` 1) can hit only entries whose tag equals `cmp_tag` (skip 2'b10, empty 2'b01, valid 2'b00).
- R8: `match_flag`, `multi_flag` and `match_addr` change only on the clock edge that accepts a search. `match_addr` is the lowest hit index, or 0 when there is no hit. `multi_flag` is 1 only when two or more entries hit.
- R9: `next_free` is the lowest-numbered entry tagged empty, and `free_valid` shows whether one exists. Both follow a write from the next cycle.
- R10: A read (`cmd_op` 3'd3) with a resolvable index sets `rd_valid` one cycle later, with that entry's data and tag on `rd_data` and `rd_tag`. Any other cycle clears `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | 0 idle, 1 load index register, 2 write, 3 read, 4 search |
| addr_src | input | 2 | Index source for write and read |
| bus_addr | input | AW | Direct index and index-register load value |
| wr_data | input | WIDTH | Write data |
| wr_tag | input | 2 | Tag stored by a write |
| key | input | WIDTH | Search key |
| mask_a | input | WIDTH | First mask |
| mask_b | input | WIDTH | Second mask |
| mask_sel | input | 2 | Active mask choice |
| cmp_forced | input | 1 | 1 selects forced search |
| cmp_tag | input | 2 | Tag filter for a forced search |
| ram_segs | input | SPW | Number of associated-data segments |
| match_flag | output | 1 | Last search hit |
| multi_flag | output | 1 | Last search hit more than one entry |
| match_addr | output | AW | Lowest hit index of last search |
| next_free | output | AW | Lowest empty index |
| free_valid | output | 1 | An empty entry exists |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | WIDTH | Read data |
| rd_tag | output | 2 | Read tag |

## Verification
The bench builds the default of 16 entries of 64 bits in 16-bit segments. With these values every split from no data segment to three data segments can be tried. The array is small enough to fill completely, so the exhausted-free case and the dropped write are reached within a few dozen cycles. Keys drawn from a small pool make single hits, multiple hits and misses all frequent in the random phase, and they occur under every tag filter and mask choice.

// File: rtl/cam_pkg.sv
package cam_pkg;
   localparam logic [1:0] TAG_VALID = 2'b00;
   localparam logic [1:0] TAG_EMPTY = 2'b01;
   localparam logic [1:0] TAG_SKIP  = 2'b10;

   localparam logic [2:0] OP_IDLE  = 3'd0;
   localparam logic [2:0] OP_LDIDX = 3'd1;
   localparam logic [2:0] OP_WRITE = 3'd2;
   localparam logic [2:0] OP_READ  = 3'd3;
   localparam logic [2:0] OP_CMP   = 3'd4;

   localparam logic [1:0] SRC_BUS   = 2'd0;
   localparam logic [1:0] SRC_IDX   = 2'd1;
   localparam logic [1:0] SRC_FREE  = 2'd2;
   localparam logic [1:0] SRC_MATCH = 2'd3;
endpackage

// File: rtl/cam_entry.sv
module cam_entry #(
   parameter int WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [WIDTH-1:0] wr_keep,
   input  logic [1:0]       wr_tag,
   input  logic [WIDTH-1:0] cmp_key,
   input  logic [WIDTH-1:0] cmp_care,
   input  logic             cmp_forced,
   input  logic [1:0]       cmp_tag,
   output logic [WIDTH-1:0] data,
   output logic [1:0]       tag,
   output logic             hit,
   output logic             is_empty
);
   import cam_pkg::*;

   logic tag_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data <= '0;
         tag  <= TAG_EMPTY;
      end else if (wr_en) begin
         data <= (data & wr_keep) | (wr_data & ~wr_keep);
         tag  <= wr_tag;
      end
   end

   always_comb begin
      tag_ok   = cmp_forced ? (tag == cmp_tag) : (tag == TAG_VALID);
      hit      = tag_ok && (((data ^ cmp_key) & cmp_care) == '0);
      is_empty = (tag == TAG_EMPTY);
   end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
   parameter int N  = 16,
   parameter int AW = 4
) (
   input  logic [N-1:0]  vec,
   output logic [AW-1:0] idx,
   output logic          any,
   output logic          multi
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = AW'(i);
      end
      any   = |vec;
      multi = |(vec & (vec - N'(1)));
   end
endmodule

// File: rtl/cam_tag_array.sv
module cam_tag_array #(
   parameter int ENTRIES = 16,
   parameter int WIDTH   = 64,
   parameter int SEG     = 16,
   parameter bit RAM_LSB = 1'b1,
   localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int NSEG   = WIDTH / SEG,
   localparam int SPW    = (NSEG > 1) ? $clog2(NSEG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cmd_op,
   input  logic [1:0]       addr_src,
   input  logic [AW-1:0]    bus_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [1:0]       wr_tag,
   input  logic [WIDTH-1:0] key,
   input  logic [WIDTH-1:0] mask_a,
   input  logic [WIDTH-1:0] mask_b,
   input  logic [1:0]       mask_sel,
   input  logic             cmp_forced,
   input  logic [1:0]       cmp_tag,
   input  logic [SPW-1:0]   ram_segs,
   output logic             match_flag,
   output logic             multi_flag,
   output logic [AW-1:0]    match_addr,
   output logic [AW-1:0]    next_free,
   output logic             free_valid,
   output logic             rd_valid,
   output logic [WIDTH-1:0] rd_data,
   output logic [1:0]       rd_tag
);
   import cam_pkg::*;

   if (WIDTH % SEG != 0) begin : g_bad_seg
      $error("WIDTH must be a multiple of SEG");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("ENTRIES must be at least 2");
   end

   logic [WIDTH-1:0] act_mask;
   logic [WIDTH-1:0] cam_field;
   logic [WIDTH-1:0] care;
   logic [WIDTH-1:0] ent_data [ENTRIES];
   logic [1:0]       ent_tag  [ENTRIES];
   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] empty_vec;
   logic [ENTRIES-1:0] wr_en_vec;
   logic [AW-1:0]    hit_idx;
   logic             hit_any;
   logic             hit_multi;
   logic [AW-1:0]    idx_reg;
   logic [AW-1:0]    tgt;
   logic             tgt_ok;

   always_comb begin
      unique case (mask_sel)
         2'd0:    act_mask = '0;
         2'd1:    act_mask = mask_a;
         2'd2:    act_mask = mask_b;
         default: act_mask = mask_a | mask_b;
      endcase
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_field
      if (RAM_LSB) begin : g_lsb
         assign cam_field[b] = (SPW+1)'(b / SEG) >= {1'b0, ram_segs};
      end else begin : g_msb
         assign cam_field[b] = (SPW+1)'(NSEG - 1 - b / SEG) >= {1'b0, ram_segs};
      end
   end

   assign care = cam_field & ~act_mask;

   always_comb begin
      tgt    = '0;
      tgt_ok = 1'b0;
      unique case (addr_src)
         SRC_BUS:   begin tgt = bus_addr;   tgt_ok = 1'b1;       end
         SRC_IDX:   begin tgt = idx_reg;    tgt_ok = 1'b1;       end
         SRC_FREE:  begin tgt = next_free;  tgt_ok = free_valid; end
         default:   begin tgt = match_addr; tgt_ok = match_flag; end
      endcase
      if (int'(tgt) >= ENTRIES) tgt_ok = 1'b0;
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign wr_en_vec[e] = (cmd_op == OP_WRITE) && tgt_ok && (tgt == AW'(e));
      cam_entry #(.WIDTH(WIDTH)) u_entry (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (wr_en_vec[e]),
         .wr_data    (wr_data),
         .wr_keep    (act_mask),
         .wr_tag     (wr_tag),
         .cmp_key    (key),
         .cmp_care   (care),
         .cmp_forced (cmp_forced),
         .cmp_tag    (cmp_tag),
         .data       (ent_data[e]),
         .tag        (ent_tag[e]),
         .hit        (hit_vec[e]),
         .is_empty   (empty_vec[e])
      );
   end

   cam_prio_enc #(.N(ENTRIES), .AW(AW)) u_hit_enc (
      .vec   (hit_vec),
      .idx   (hit_idx),
      .any   (hit_any),
      .multi (hit_multi)
   );

   logic free_multi;
   cam_prio_enc #(.N(ENTRIES), .AW(AW)) u_free_enc (
      .vec   (empty_vec),
      .idx   (next_free),
      .any   (free_valid),
      .multi (free_multi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_reg    <= '0;
         match_flag <= 1'b0;
         multi_flag <= 1'b0;
         match_addr <= '0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         rd_tag     <= 2'b00;
      end else begin
         rd_valid <= 1'b0;
         unique case (cmd_op)
            OP_LDIDX: idx_reg <= bus_addr;
            OP_CMP: begin
               match_flag <= hit_any;
               multi_flag <= hit_multi;
               match_addr <= hit_any ? hit_idx : '0;
            end
            OP_READ: begin
               if (tgt_ok) begin
                  rd_valid <= 1'b1;
                  rd_data  <= ent_data[tgt];
                  rd_tag   <= ent_tag[tgt];
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cam_tag_array_chk.sv
module cam_tag_array_chk #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    cmd_op,
   input logic [1:0]    addr_src,
   input logic          free_valid,
   input logic [AW-1:0] next_free,
   input logic          match_flag,
   input logic          multi_flag,
   input logic [AW-1:0] match_addr,
   input logic          rd_valid
);
   a_r1_reset_free: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (free_valid && next_free == '0 && !match_flag));

   a_r8_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      multi_flag |-> match_flag);

   a_r8_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op != 3'd4) |=> ($stable(match_flag) && $stable(multi_flag) && $stable(match_addr)));

   a_r8_miss_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !match_flag |-> (match_addr == '0));

   a_r10_direct_read: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd3 && addr_src == 2'd0) |=> rd_valid);

   a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd2 && addr_src == 2'd2 && !free_valid) |=> !free_valid);
endmodule

bind cam_tag_array cam_tag_array_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_op     (cmd_op),
   .addr_src   (addr_src),
   .free_valid (free_valid),
   .next_free  (next_free),
   .match_flag (match_flag),
   .multi_flag (multi_flag),
   .match_addr (match_addr),
   .rd_valid   (rd_valid)
);

// File: tb/cam_tag_array_tb.sv
module cam_tag_array_tb;
   localparam int N  = 16;
   localparam int W  = 64;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    cmd_op = 3'd0;
   logic [1:0]    addr_src = 2'd0;
   logic [AW-1:0] bus_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [1:0]    wr_tag = 2'b00;
   logic [W-1:0]  key = '0;
   logic [W-1:0]  mask_a = '0;
   logic [W-1:0]  mask_b = '0;
   logic [1:0]    mask_sel = 2'd0;
   logic          cmp_forced = 1'b0;
   logic [1:0]    cmp_tag = 2'b00;
   logic [1:0]    ram_segs = 2'd0;
   logic          match_flag, multi_flag, free_valid, rd_valid;
   logic [AW-1:0] match_addr, next_free;
   logic [W-1:0]  rd_data;
   logic [1:0]    rd_tag;

   cam_tag_array u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .addr_src(addr_src),
      .bus_addr(bus_addr), .wr_data(wr_data), .wr_tag(wr_tag), .key(key),
      .mask_a(mask_a), .mask_b(mask_b), .mask_sel(mask_sel),
      .cmp_forced(cmp_forced), .cmp_tag(cmp_tag), .ram_segs(ram_segs),
      .match_flag(match_flag), .multi_flag(multi_flag), .match_addr(match_addr),
      .next_free(next_free), .free_valid(free_valid), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_tag(rd_tag));

   always #2.5 clk = ~clk;

   // reference model state
   logic [W-1:0] m_mem [N];
   logic [1:0]   m_tag [N];
   int           m_idx, m_addr;
   bit           m_flag, m_multi, m_rdv;
   logic [W-1:0] m_rdd;
   logic [1:0]   m_rdt;
   int vectors = 0, errors = 0;
   string cur_req = "R1";

   function automatic int first_free();
      for (int i = 0; i < N; i++) if (m_tag[i] == 2'b01) return i;
      return -1;
   endfunction

   function automatic logic [W-1:0] act_mask();
      case (mask_sel)
         2'd0: return '0;
         2'd1: return mask_a;
         2'd2: return mask_b;
         default: return mask_a | mask_b;
      endcase
   endfunction

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin m_mem[i] = '0; m_tag[i] = 2'b01; end
      m_idx = 0; m_addr = 0; m_flag = 0; m_multi = 0; m_rdv = 0; m_rdd = '0; m_rdt = 0;
   endtask

   task automatic model_clock();
      int t; bit ok; int hits; int low; logic [W-1:0] mk;
      mk = act_mask();
      case (addr_src)
         2'd0: begin t = int'(bus_addr); ok = 1; end
         2'd1: begin t = m_idx; ok = 1; end
         2'd2: begin t = first_free(); ok = (t >= 0); end
         default: begin t = m_addr; ok = m_flag; end
      endcase
      m_rdv = 0;
      case (cmd_op)
         3'd1: m_idx = int'(bus_addr);
         3'd2: if (ok) begin
            for (int b = 0; b < W; b++) if (!mk[b]) m_mem[t][b] = wr_data[b];
            m_tag[t] = wr_tag;
         end
         3'd3: if (ok) begin m_rdv = 1; m_rdd = m_mem[t]; m_rdt = m_tag[t]; end
         3'd4: begin
            hits = 0; low = 0;
            for (int e = N - 1; e >= 0; e--) begin
               bit h;
               h = cmp_forced ? (m_tag[e] == cmp_tag) : (m_tag[e] == 2'b00);
               for (int b = 0; b < W; b++)
                  if (b >= 16 * int'(ram_segs) && !mk[b] && m_mem[e][b] != key[b]) h = 0;
               if (h) begin hits++; low = e; end
            end
            m_flag = (hits > 0); m_multi = (hits > 1); m_addr = low;
         end
         default: ;
      endcase
   endtask

   task automatic check(input bit c, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      if (!c) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      int nf;
      nf = first_free();
      vectors++;
      check(match_flag == m_flag, "R8 match_flag", W'(match_flag), W'(m_flag));
      check(multi_flag == m_multi, "R8 multi_flag", W'(multi_flag), W'(m_multi));
      check(int'(match_addr) == m_addr, "R8 match_addr", W'(match_addr), W'(m_addr));
      check(free_valid == (nf >= 0), "R9 free_valid", W'(free_valid), W'(nf >= 0));
      if (nf >= 0) check(int'(next_free) == nf, "R9 next_free", W'(next_free), W'(nf));
      check(rd_valid == m_rdv, "R10 rd_valid", W'(rd_valid), W'(m_rdv));
      if (m_rdv) begin
         check(rd_data == m_rdd, "R10 rd_data", rd_data, m_rdd);
         check(rd_tag == m_rdt, "R10 rd_tag", W'(rd_tag), W'(m_rdt));
      end
   endtask

   task automatic step();
      @(posedge clk);
      if (rst_n) model_clock(); else model_reset();
      @(negedge clk);
      compare();
      cmd_op = 3'd0;
   endtask

   task automatic op_wr(input logic [1:0] src, input int a, input logic [W-1:0] d, input logic [1:0] tg);
      cmd_op = 3'd2; addr_src = src; bus_addr = AW'(a); wr_data = d; wr_tag = tg; step();
   endtask
   task automatic op_rd(input logic [1:0] src, input int a);
      cmd_op = 3'd3; addr_src = src; bus_addr = AW'(a); step();
   endtask
   task automatic op_cmp(input logic [W-1:0] k, input bit f, input logic [1:0] tg);
      cmd_op = 3'd4; key = k; cmp_forced = f; cmp_tag = tg; step();
   endtask

   localparam logic [W-1:0] DA = 64'hA5A5_1234_5678_9ABC;
   localparam logic [W-1:0] DB = 64'h0F0F_F0F0_3333_CCCC;
   localparam logic [W-1:0] DC = 64'h1111_2222_3333_4444;
   localparam logic [W-1:0] DD = 64'hDEAD_BEEF_0BAD_F00D;

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin : stim
      logic [W-1:0] pool [4];
      pool[0] = DA; pool[1] = DB; pool[2] = DC; pool[3] = '0;
      model_reset();
      @(negedge clk);
      step(); step();
      rst_n = 1'b1;
      cur_req = "R1"; step();
      op_rd(2'd0, 6);                                   // R1: empty entry reads zero
      cur_req = "R2";
      op_wr(2'd0, 3, DA, 2'b00);
      cmd_op = 3'd1; bus_addr = 4'd5; step();
      op_wr(2'd1, 0, DB, 2'b00);
      op_wr(2'd2, 0, DC, 2'b00);                        // lands at 0
      op_wr(2'd2, 0, DD, 2'b10);                        // lands at 1, skip
      op_rd(2'd1, 0); op_rd(2'd0, 0); op_rd(2'd0, 1);
      cur_req = "R6";
      op_cmp(DB, 0, 2'b00);
      op_cmp(DD, 0, 2'b00);                             // skipped entry: no hit
      cur_req = "R7";
      op_cmp(DD, 1, 2'b10);
      op_cmp('0, 1, 2'b01);                             // many empty entries
      op_cmp(DA, 1, 2'b10);
      cur_req = "R4";
      op_wr(2'd0, 7, DA ^ 64'h1, 2'b00);
      op_cmp(DA, 0, 2'b00);
      mask_a = 64'h1; mask_sel = 2'd1;
      op_cmp(DA, 0, 2'b00);
      cur_req = "R2";
      mask_sel = 2'd0;
      op_wr(2'd3, 0, DC, 2'b00);                        // via last hit index 3
      op_rd(2'd0, 3);
      op_cmp(64'h5, 0, 2'b00);
      op_wr(2'd3, 0, DD, 2'b00);                        // no hit: dropped
      cur_req = "R5";
      op_wr(2'd0, 9, {DB[63:16], 16'h7777}, 2'b00);
      op_cmp(DB, 0, 2'b00);
      ram_segs = 2'd1; op_cmp(DB, 0, 2'b00);
      ram_segs = 2'd3; op_cmp({DB[63:48], 48'h0}, 0, 2'b00);
      ram_segs = 2'd0;
      cur_req = "R3";
      mask_b = 64'hFFFF_0000_FFFF_0000; mask_sel = 2'd2;
      op_wr(2'd0, 5, '1, 2'b00); op_rd(2'd0, 5);
      mask_sel = 2'd3; op_wr(2'd0, 5, '0, 2'b00); op_rd(2'd0, 5);
      mask_sel = 2'd0;
      cur_req = "R9";
      for (int i = 0; i < N; i++) op_wr(2'd2, 0, W'(i) << 8, 2'b00);
      op_wr(2'd2, 0, DA, 2'b00);                        // full: dropped
      op_rd(2'd2, 0);
      op_wr(2'd0, 12, '0, 2'b01);
      op_wr(2'd0, 4, '0, 2'b01);
      cur_req = "R8";
      for (int i = 0; i < 600; i++) begin
         int r;
         r = $urandom_range(0, 9);
         mask_sel = 2'($urandom_range(0, 3));
         mask_a = {$urandom, $urandom} & {$urandom, $urandom};
         mask_b = 64'hFF << (8 * $urandom_range(0, 7));
         ram_segs = 2'($urandom_range(0, 3));
         bus_addr = AW'($urandom_range(0, N - 1));
         addr_src = 2'($urandom_range(0, 3));
         wr_data = pool[$urandom_range(0, 3)];
         wr_tag = 2'($urandom_range(0, 2));
         key = pool[$urandom_range(0, 3)];
         cmp_forced = 1'($urandom_range(0, 1));
         cmp_tag = 2'($urandom_range(0, 2));
         cmd_op = (r < 3) ? 3'd4 : (r < 6) ? 3'd2 : (r < 8) ? 3'd3 : (r < 9) ? 3'd1 : 3'd0;
         step();
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule